// File: doc/BRIEF.md
# Self-Repairing One-Hot Ring Controller

This block is a small ring-position controller whose state is held one-hot and guarded by a second, compact copy of the same state. That copy is a binary index with an even-parity bit. A one-hot word already has minimum distance two, so together with the parity-protected index the pair of copies reaches a combined distance of at least three. A single flipped flop in either copy is therefore repaired without losing the controller's place.

Every cycle the block decides which copy to trust. It recomputes the parity of the stored index and compares it with the stored parity bit. A mismatch means the shadow is damaged, and the one-hot register is used. A match means the shadow is sound, and its index, expanded back to one-hot, is used. This repaired state drives the transition logic and the outputs. All three registers reload from the repaired path on every edge, including the cycles in which the position holds, so a repair never waits on a transition. Upset-injection masks let a bench or a fault campaign flip any stored bit at a chosen edge.

Top module: `ohfsm_shadow_guard`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `state_o` is 1 (position 0 in bit 0), `idx_o` is 0, `last_o` is 0 and `upset_o` is 0.
- R2: At an edge where `adv_i` is 1, the position moves from index k to index k+1, wrapping from N-1 to 0. `adv_i` takes priority over `rev_i` when both are 1.
- R3: At an edge where `rev_i` is 1 and `adv_i` is 0, the position moves from index k to index k-1, wrapping from 0 to N-1.
- R4: At an edge where both `adv_i` and `rev_i` are 0, the position is unchanged.
- R5: Bit i of `flip_hot_i` inverts bit i of the one-hot register as it is loaded at that edge. After a single such flip, `state_o` still shows the correct position and `upset_o` is 1 for the following cycle. With no further flip, `upset_o` returns to 0 one cycle later.
- R6: Bit j of `flip_bin_i` inverts bit j of the stored binary index as it is loaded. A single such flip leaves `state_o` correct and raises `upset_o` for one cycle, as in R5.
- R7: `flip_par_i` inverts the stored parity bit, the XOR of all index bits, as it is loaded. A single such flip leaves `state_o` correct and raises `upset_o` for one cycle, as in R5.
- R8: A flip injected at the same edge as a transition (R2 or R3) does not change where the controller moves, and the following transition starts from the correct position.
- R9: `idx_o` is the binary index of the one-hot `state_o`, and `last_o` is 1 exactly when that index is N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Step to the next higher position |
| rev_i | input | 1 | Step to the next lower position |
| flip_hot_i | input | N | Upset-injection mask for the one-hot register |
| flip_bin_i | input | W | Upset-injection mask for the binary shadow index |
| flip_par_i | input | 1 | Upset injection for the shadow parity bit |
| state_o | output | N | Repaired one-hot state |
| idx_o | output | W | Binary index of the repaired state |
| last_o | output | 1 | Repaired state is the highest position |
| upset_o | output | 1 | The two stored copies disagree this cycle |

## Verification
Repair and transition can fall in the same cycle. A stored bit may be damaged at the very edge at which the controller steps, so the next step has to be taken from the repaired state rather than from the damaged register. The bench provokes this by asserting a flip mask together with `adv_i` or `rev_i` at one edge and stepping again at the next. It judges the outcome by comparing the position and the upset flag, cycle by cycle, against an independent model of the ring, which must never lose its place.

// File: rtl/ohfsm_shadow_guard.sv
module ohfsm_shadow_guard #(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv_i,
  input  logic                 rev_i,
  input  logic [N-1:0]         flip_hot_i,
  input  logic [$clog2(N)-1:0] flip_bin_i,
  input  logic                 flip_par_i,
  output logic [N-1:0]         state_o,
  output logic [$clog2(N)-1:0] idx_o,
  output logic                 last_o,
  output logic                 upset_o
);

  localparam int W = $clog2(N);
  localparam logic [N-1:0] HOT0 = {{(N-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] to_index(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (v[i]) r = r | i[W-1:0];
    return r;
  endfunction

  logic [N-1:0] hot_q;
  logic [W-1:0] bin_q;
  logic         par_q;

  logic         par_bad;
  logic [N-1:0] expand;
  logic [N-1:0] fixed;
  logic [N-1:0] nxt;
  logic [W-1:0] nxt_bin;

  assign par_bad = (^bin_q) ^ par_q;
  assign expand  = HOT0 << bin_q;
  assign fixed   = par_bad ? hot_q : expand;

  assign nxt = adv_i ? {fixed[N-2:0], fixed[N-1]} :
               rev_i ? {fixed[0], fixed[N-1:1]}   : fixed;
  assign nxt_bin = to_index(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      hot_q <= HOT0;
      bin_q <= '0;
      par_q <= 1'b0;
    end else begin
      hot_q <= nxt ^ flip_hot_i;
      bin_q <= nxt_bin ^ flip_bin_i;
      par_q <= (^nxt_bin) ^ flip_par_i;
    end
  end

  assign state_o = fixed;
  assign idx_o   = to_index(fixed);
  assign last_o  = fixed[N-1];
  assign upset_o = par_bad | (hot_q != expand);

  logic no_flip;
  assign no_flip = (flip_hot_i == '0) && (flip_bin_i == '0) && !flip_par_i;

  assert_reset_home_R1: assert property (@(posedge clk)
    rst |=> (state_o == HOT0) && !upset_o);

  assert_advance_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> state_o == {$past(state_o[N-2:0]), $past(state_o[N-1])});

  assert_reverse_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (rev_i && !adv_i) |=> state_o == {$past(state_o[0]), $past(state_o[N-1:1])});

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!adv_i && !rev_i) |=> $stable(state_o));

  assert_upset_clears_R5: assert property (@(posedge clk) disable iff (rst)
    no_flip |=> !upset_o);

  assert_single_hot_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(state_o) == 1);

  assert_last_matches_R9: assert property (@(posedge clk) disable iff (rst)
    last_o == (idx_o == W'(N-1)));

endmodule

// File: tb/ohfsm_shadow_guard_tb_top.sv
module ohfsm_shadow_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int WB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0, rev = 1'b0;
  logic [NS-1:0] fh = '0;
  logic [WB-1:0] fb = '0;
  logic fp = 1'b0;
  logic [NS-1:0] st;
  logic [WB-1:0] idx;
  logic last, upset;

  int checks = 0, fails = 0;
  int midx = 0;
  bit done = 0;

  typedef struct packed {
    logic [WB-1:0] ix;
    logic          up;
    logic [3:0]    tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ohfsm_shadow_guard #(.N(NS)) dut_i (
    .clk(clk), .rst(rst), .adv_i(adv), .rev_i(rev),
    .flip_hot_i(fh), .flip_bin_i(fb), .flip_par_i(fp),
    .state_o(st), .idx_o(idx), .last_o(last), .upset_o(upset)
  );

  task automatic chk(input bit ok, input int tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic r, input logic [NS-1:0] h,
                      input logic [WB-1:0] b, input logic p, input int tag);
    item_t it;
    @(negedge clk);
    adv = a; rev = r; fh = h; fb = b; fp = p;
    if (a) midx = (midx + 1) % NS;
    else if (r) midx = (midx + NS - 1) % NS;
    it.ix = WB'(midx);
    it.up = (h != '0) || (b != '0) || p;
    it.tag = 4'(tag);
    sb.push_back(it);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk(st == (NS'(1) << it.ix), int'(it.tag), int'(st), int'(NS'(1) << it.ix));
        chk(idx == it.ix, 9, int'(idx), int'(it.ix));              // R9
        chk(last == (it.ix == WB'(NS-1)), 9, int'(last), int'(it.ix == WB'(NS-1)));
        chk(upset == it.up, int'(it.tag), int'(upset), int'(it.up));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(st == NS'(1), 1, int'(st), 1);
    chk(idx == '0, 1, int'(idx), 0);
    chk(!upset && !last, 1, int'({upset, last}), 0);
    rst = 1'b0;
    step(0, 0, '0, '0, 0, 1);
    // R2: advance through wrap
    for (int i = 0; i < NS + 1; i++) step(1, 0, '0, '0, 0, 2);
    // R3: reverse through wrap
    for (int i = 0; i < NS + 2; i++) step(0, 1, '0, '0, 0, 3);
    // R4: hold
    for (int i = 0; i < 3; i++) step(0, 0, '0, '0, 0, 4);
    // R2: advance has priority
    step(1, 1, '0, '0, 0, 2);
    step(1, 1, '0, '0, 0, 2);
    // R5: every one-hot bit, in different positions
    for (int i = 0; i < NS; i++) begin
      step(0, 0, NS'(1) << i, '0, 0, 5);
      step(0, 0, '0, '0, 0, 5);
      step(1, 0, '0, '0, 0, 5);
    end
    // R6: every index bit
    for (int j = 0; j < WB; j++) begin
      step(0, 0, '0, WB'(1) << j, 0, 6);
      step(0, 0, '0, '0, 0, 6);
      step(0, 1, '0, '0, 0, 6);
    end
    // R7: parity bit
    step(0, 0, '0, '0, 1, 7);
    step(0, 0, '0, '0, 0, 7);
    // R8: flips at the same edge as a transition, then step again
    for (int i = 0; i < NS; i++) begin
      step(1, 0, NS'(1) << i, '0, 0, 8);
      step(1, 0, '0, '0, 0, 8);
    end
    for (int j = 0; j < WB; j++) begin
      step(0, 1, '0, WB'(1) << j, 0, 8);
      step(0, 1, '0, '0, 0, 8);
    end
    step(1, 0, '0, '0, 1, 8);
    step(0, 1, '0, '0, 0, 8);
    // back-to-back single flips in alternating copies
    step(0, 0, NS'(4), '0, 0, 8);
    step(1, 0, '0, WB'(2), 0, 8);
    step(0, 0, '0, '0, 1, 8);
    step(0, 0, '0, '0, 0, 8);
    @(negedge clk);
    adv = 0; rev = 0; fh = '0; fb = '0; fp = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule